// File: doc/BRIEF.md
# Flash Buffered Program Sequencer

This block carries out multi-byte programming for a flash command port. A host opens a transfer by writing the start command with an address in the target 64 KB block. It then writes a byte count, the data bytes, and finally a commit byte. The data bytes are collected in a 32-entry staging buffer, so they may arrive in any order inside a window that the first data byte opens. On commit, the block walks the buffer from index 0 upward. For each entry it performs one AND-write to the storage array, then reads the same location back and compares it with the intended byte.

Sequence faults end the transfer at once, free the buffer and raise error flags in the main status byte. A faulty address or a wrong commit byte is a sequence fault. A read-back mismatch raises only the program-error flag. The block also reports which view a read of the flash should return: array contents, main status or extended status. Other command bytes written while no transfer is open are left to neighbouring logic and ignored here.

Top module: `flash_bufprog`

## Requirements
- R1: After reset, `status` is 0x80 (bit 7 = ready), `ext_status` is 0x00, `read_mode` is 0 (array view) and `mem_we` is low.
- R2: With no transfer open, a write of 0xE8 records the address's 64 KB block, sets `ext_status` to 0x80 (buffer available) and `read_mode` to 2 (extended status view), and fills every staging entry with 0xFF. Any other byte written while no transfer is open changes no output.
- R3: The write after 0xE8 is the count. Only its low 5 bits N are used, and N+1 data bytes are then expected. This write clears status bit 7 and sets `read_mode` to 1 (status view).
- R4: The first data byte must carry an address whose bits above bit 15 equal those of the address given with 0xE8. Its address becomes the window start S and it fills entry 0. If the block differs, the transfer aborts.
- R5: Every later data byte must have an address A with S <= A <= S+N. It fills entry A-S, and a later write to the same address replaces the earlier byte. An address outside the window aborts the transfer.
- R6: The write after the last data byte must be 0xD0 to start the commit. Any other value aborts the transfer, and no array write takes place.
- R7: An abort ORs 0xB0 into `status` (ready, sequence error 0x20, program error 0x10) and leaves `read_mode` at 1.
- R8: The commit issues exactly N+1 array writes, to addresses S, S+1, ..., S+N in ascending order. Each carries its staged byte, and entries never written carry 0xFF.
- R9: Each array write lasts one cycle and is followed by one read-back cycle at the same address. A mismatch ORs 0x10 into `status`. Bit 7 stays low for the whole commit and is set when the last byte has been checked.
- R10: Writes on the command port during the commit are ignored.
- R11: The buffer is free again after a commit or an abort, so a following 0xE8 is accepted.
- R12: Error bits 0x20 and 0x10 stay set through later transfers until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command/data write strobe, one cycle per byte |
| cmd_addr | input | AW (21) | Byte address of the write |
| cmd_data | input | 8 | Written byte |
| status | output | 8 | Main status: bit 7 ready, bit 5 sequence error, bit 4 program error |
| ext_status | output | 8 | Extended status: bit 7 buffer available |
| read_mode | output | 2 | Read view: 0 array, 1 status, 2 extended status |
| mem_we | output | 1 | Array AND-write strobe |
| mem_addr | output | AW (21) | Array address for write and read-back |
| mem_wdata | output | 8 | Byte ANDed into the array |
| mem_rdata | input | 8 | Array read data for `mem_addr`, available in the same cycle |

## Verification
The checker relies on the array returning read data for `mem_addr` in the same cycle. It also assumes that separate transfers are spaced far enough apart that two array writes exactly two cycles apart always belong to the same commit. The stimulus meets the first condition with a combinational array model. It meets the second because every transfer needs at least four command writes between commits. Command bytes are driven on the falling edge, and every address stays inside the modelled array, except the deliberate wrong-block byte, which aborts before any array access.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

    localparam logic [7:0] CMD_BUF_START = 8'hE8;
    localparam logic [7:0] CMD_COMMIT    = 8'hD0;
    localparam logic [7:0] ST_READY      = 8'h80;
    localparam logic [7:0] ST_SEQ_ERR    = 8'h20;
    localparam logic [7:0] ST_PGM_ERR    = 8'h10;
    localparam logic [7:0] XS_BUF_AVAIL  = 8'h80;
    localparam logic [7:0] BYTE_ERASED   = 8'hFF;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_COUNT,
        PH_DATA,
        PH_CONFIRM,
        PH_WRITE,
        PH_VERIFY
    } phase_t;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_STATUS = 2'd1,
        RM_EXT    = 2'd2
    } rmode_t;

    typedef struct packed {
        logic in_block;
        logic in_window;
    } addr_chk_t;

    function automatic logic [7:0] abort_status(input logic [7:0] cur);
        return cur | ST_READY | ST_SEQ_ERR | ST_PGM_ERR;
    endfunction

endpackage

// File: rtl/fbp_window.sv
module fbp_window
    import fbp_pkg::*;
#(
    parameter int AW       = 21,
    parameter int BLK_BITS = 16,
    parameter int IDX_W    = 5
) (
    input  logic [AW-1:0]          cand,
    input  logic [AW-BLK_BITS-1:0] ref_blk,
    input  logic [AW-1:0]          win_start,
    input  logic [IDX_W-1:0]       last_off,
    output addr_chk_t              chk,
    output logic [IDX_W-1:0]       off
);
    localparam int PAD = AW - IDX_W;

    logic [AW-1:0] diff;
    logic [AW-1:0] last_wide;

    assign diff          = cand - win_start;
    assign last_wide     = {{PAD{1'b0}}, last_off};
    assign chk.in_block  = (cand[AW-1:BLK_BITS] == ref_blk);
    assign chk.in_window = (cand >= win_start) && (diff <= last_wide);
    assign off           = diff[IDX_W-1:0];
endmodule

// File: rtl/fbp_buffer.sv
module fbp_buffer
    import fbp_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             fill,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [7:0]       wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [7:0]       rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [7:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (fill)
                slot[g] <= BYTE_ERASED;
            else if (we && (widx == IDX_W'(g)))
                slot[g] <= wdata;
        end
    end

    assign rdata = slot[ridx];
endmodule

// File: rtl/flash_bufprog.sv
module flash_bufprog
    import fbp_pkg::*;
#(
    parameter int AW       = 21,
    parameter int BLK_BITS = 16,
    parameter int IDX_W    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_we,
    input  logic [AW-1:0] cmd_addr,
    input  logic [7:0]    cmd_data,
    output logic [7:0]    status,
    output logic [7:0]    ext_status,
    output logic [1:0]    read_mode,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata
);
    localparam int BW  = AW - BLK_BITS;
    localparam int CW  = IDX_W + 1;
    localparam int PAD = AW - IDX_W;

    phase_t           phase;
    rmode_t           rmode;
    logic [BW-1:0]    rec_blk;
    logic [AW-1:0]    start_addr;
    logic [IDX_W-1:0] last_off;
    logic [CW-1:0]    left;
    logic             first_pending;
    logic [IDX_W-1:0] cidx;
    logic [7:0]       stat_q;
    logic [7:0]       xstat_q;

    addr_chk_t        chk;
    logic [IDX_W-1:0] woff;
    logic             data_ok;
    logic             buf_fill;
    logic             buf_we;
    logic [IDX_W-1:0] buf_widx;
    logic [7:0]       buf_rd;
    logic             verify_bad;

    fbp_window #(.AW(AW), .BLK_BITS(BLK_BITS), .IDX_W(IDX_W)) u_win (
        .cand      (cmd_addr),
        .ref_blk   (rec_blk),
        .win_start (start_addr),
        .last_off  (last_off),
        .chk       (chk),
        .off       (woff)
    );

    assign data_ok  = first_pending ? chk.in_block : chk.in_window;
    assign buf_fill = (phase == PH_IDLE) && cmd_we && (cmd_data == CMD_BUF_START);
    assign buf_we   = (phase == PH_DATA) && cmd_we && data_ok;
    assign buf_widx = first_pending ? '0 : woff;

    fbp_buffer #(.IDX_W(IDX_W)) u_buf (
        .clk   (clk),
        .fill  (buf_fill),
        .we    (buf_we),
        .widx  (buf_widx),
        .wdata (cmd_data),
        .ridx  (cidx),
        .rdata (buf_rd)
    );

    assign mem_we     = (phase == PH_WRITE);
    assign mem_addr   = start_addr + {{PAD{1'b0}}, cidx};
    assign mem_wdata  = buf_rd;
    assign verify_bad = (mem_rdata != buf_rd);

    assign status     = stat_q;
    assign ext_status = xstat_q;
    assign read_mode  = rmode;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase         <= PH_IDLE;
            rmode         <= RM_ARRAY;
            rec_blk       <= '0;
            start_addr    <= '0;
            last_off      <= '0;
            left          <= '0;
            first_pending <= 1'b0;
            cidx          <= '0;
            stat_q        <= ST_READY;
            xstat_q       <= 8'h00;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (buf_fill) begin
                        rec_blk <= cmd_addr[AW-1:BLK_BITS];
                        xstat_q <= XS_BUF_AVAIL;
                        rmode   <= RM_EXT;
                        phase   <= PH_COUNT;
                    end
                end
                PH_COUNT: begin
                    if (cmd_we) begin
                        last_off      <= cmd_data[IDX_W-1:0];
                        left          <= CW'(cmd_data[IDX_W-1:0]) + CW'(1);
                        first_pending <= 1'b1;
                        stat_q        <= stat_q & ~ST_READY;
                        rmode         <= RM_STATUS;
                        phase         <= PH_DATA;
                    end
                end
                PH_DATA: begin
                    if (cmd_we) begin
                        if (!data_ok) begin
                            stat_q <= abort_status(stat_q);
                            phase  <= PH_IDLE;
                        end else begin
                            if (first_pending) begin
                                start_addr    <= cmd_addr;
                                first_pending <= 1'b0;
                            end
                            left <= left - CW'(1);
                            if (left == CW'(1))
                                phase <= PH_CONFIRM;
                        end
                    end
                end
                PH_CONFIRM: begin
                    if (cmd_we) begin
                        if (cmd_data == CMD_COMMIT) begin
                            cidx  <= '0;
                            phase <= PH_WRITE;
                        end else begin
                            stat_q <= abort_status(stat_q);
                            phase  <= PH_IDLE;
                        end
                    end
                end
                PH_WRITE: begin
                    phase <= PH_VERIFY;
                end
                PH_VERIFY: begin
                    if (cidx == last_off) begin
                        stat_q <= stat_q | ST_READY | (verify_bad ? ST_PGM_ERR : 8'h00);
                        phase  <= PH_IDLE;
                    end else begin
                        if (verify_bad)
                            stat_q <= stat_q | ST_PGM_ERR;
                        cidx  <= cidx + IDX_W'(1);
                        phase <= PH_WRITE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fbp_checker.sv
module fbp_checker #(
    parameter int AW = 21
) (
    input logic          clk,
    input logic          rst,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    status,
    input logic [7:0]    ext_status,
    input logic [1:0]    read_mode
);
    assert_ready_low_commit_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !status[7]);

    assert_write_then_verify_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> !mem_we);

    assert_verify_same_addr_R9: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> $stable(mem_addr));

    assert_ascending_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we, 2)) |-> (mem_addr == $past(mem_addr, 2) + {{(AW-1){1'b0}}, 1'b1}));

    assert_ext_view_avail_R2: assert property (@(posedge clk) disable iff (rst)
        (read_mode == 2'd2) |-> (ext_status == 8'h80));

    assert_seq_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        status[5] |=> status[5]);

    assert_pgm_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        status[4] |=> status[4]);
endmodule

bind flash_bufprog fbp_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .status     (status),
    .ext_status (ext_status),
    .read_mode  (read_mode)
);

// File: tb/tb_flash_bufprog.sv
module tb_flash_bufprog;
    localparam int AW = 21;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [7:0]    d;
    } wr_item_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_we = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [7:0]    cmd_data = '0;
    logic [7:0]    status, ext_status, mem_wdata, mem_rdata;
    logic [1:0]    read_mode;
    logic          mem_we;
    logic [AW-1:0] mem_addr;

    logic [7:0] bmem [1024];
    wr_item_t   expq [$];
    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    flash_bufprog #(.AW(AW)) dut (
        .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .status(status), .ext_status(ext_status), .read_mode(read_mode),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    assign mem_rdata = bmem[mem_addr[9:0]];
    always @(posedge clk) if (mem_we) bmem[mem_addr[9:0]] <= bmem[mem_addr[9:0]] & mem_wdata;

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R10 unexpected array write addr=%h data=%h expected none", mem_addr, mem_wdata);
            end else begin
                wr_item_t it;
                it = expq.pop_front();
                if (it.a != mem_addr || it.d != mem_wdata) begin
                    bad++;
                    $display("FAIL R8 array write got %h:%h expected %h:%h", mem_addr, mem_wdata, it.a, it.d);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic expect_wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr_item_t it;
        it.a = a; it.d = d;
        expq.push_back(it);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!status[7] && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req, {31'd0, status[7]}, 32'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = 8'hFF;
        do_reset();

        // R1 reset state
        chk("R1 status", status, 8'h80);
        chk("R1 ext", ext_status, 8'h00);
        chk("R1 mode", read_mode, 2'd0);
        chk("R1 we", mem_we, 1'b0);

        // R2 foreign byte in idle ignored
        put(21'h100, 8'h70);
        chk("R2 ignore status", status, 8'h80);
        chk("R2 ignore mode", read_mode, 2'd0);
        chk("R2 ignore ext", ext_status, 8'h00);

        // main transfer, holes and overwrite
        put(21'h100, 8'hE8);
        chk("R2 ext", ext_status, 8'h80);
        chk("R2 mode", read_mode, 2'd2);
        put(21'h100, 8'hE3);             // R3 low 5 bits -> N=3
        chk("R3 ready low", status, 8'h00);
        chk("R3 mode", read_mode, 2'd1);
        put(21'h104, 8'h5A);             // R4 first byte sets S
        put(21'h107, 8'h3C);             // R5 upper edge S+N
        put(21'h105, 8'h12);
        put(21'h107, 8'hC3);             // R5 replace
        expect_wr(21'h104, 8'h5A);
        expect_wr(21'h105, 8'h12);
        expect_wr(21'h106, 8'hFF);
        expect_wr(21'h107, 8'hC3);
        put(21'h000, 8'hD0);
        put(21'h000, 8'hE8);             // R10 ignored during commit
        chk("R9 ready low during commit", status[7], 1'b0);
        chk("R10 mode kept", read_mode, 2'd1);
        wait_ready("R9 ready after commit");
        chk("R9 status clean", status, 8'h80);
        chk("R10 mode after commit", read_mode, 2'd1);
        chk("R8 queue drained", expq.size(), 0);
        chk("R8 mem 104", bmem[10'h104], 8'h5A);
        chk("R8 mem 106 hole", bmem[10'h106], 8'hFF);
        chk("R8 mem 107", bmem[10'h107], 8'hC3);

        // R4 wrong block first byte
        put(21'h200, 8'hE8);             // R11 accepted after commit
        chk("R11 accept after commit", read_mode, 2'd2);
        put(21'h200, 8'h01);
        put(21'h10200, 8'h55);
        chk("R4 abort status", status, 8'hB0);
        chk("R7 mode after abort", read_mode, 2'd1);
        put(21'h200, 8'hE8);
        chk("R11 accept after abort", read_mode, 2'd2);
        chk("R11 ext", ext_status, 8'h80);
        put(21'h200, 8'h00);
        put(21'h204, 8'h11);
        expect_wr(21'h204, 8'h11);
        put(21'h200, 8'hD0);
        wait_ready("R9 ready");
        chk("R12 sticky", status, 8'hB0);
        chk("R8 mem 204", bmem[10'h204], 8'h11);

        // R5 above window
        do_reset();
        put(21'h300, 8'hE8);
        put(21'h300, 8'h02);
        put(21'h300, 8'h01);
        put(21'h303, 8'h02);
        chk("R5 above abort", status, 8'hB0);

        // R5 below window
        do_reset();
        put(21'h310, 8'hE8);
        put(21'h310, 8'h02);
        put(21'h310, 8'h01);
        put(21'h30F, 8'h02);
        chk("R5 below abort", status, 8'hB0);

        // R6 bad commit byte
        do_reset();
        put(21'h400, 8'hE8);
        put(21'h400, 8'h00);
        put(21'h400, 8'h77);
        put(21'h400, 8'hFF);
        chk("R6 abort status", status, 8'hB0);
        repeat (4) @(negedge clk);
        chk("R6 no write", bmem[10'h400], 8'hFF);

        // R9 read-back mismatch
        do_reset();
        bmem[10'h500] = 8'h0F;
        put(21'h500, 8'hE8);
        put(21'h500, 8'h00);
        put(21'h500, 8'hF0);
        expect_wr(21'h500, 8'hF0);
        put(21'h500, 8'hD0);
        chk("R9 write cycle ready low", {mem_we, status[7]}, 2'b10);
        wait_ready("R9 ready");
        chk("R9 program error", status, 8'h90);
        chk("R9 mem anded", bmem[10'h500], 8'h00);

        // full 32-byte buffer, reverse arrival
        put(21'h600, 8'hE8);
        put(21'h600, 8'h1F);
        put(21'h600, 8'hA5);
        for (int i = 31; i >= 1; i--) put(21'h600 + 21'(i), 8'(i) ^ 8'hA5);
        for (int i = 0; i < 32; i++) expect_wr(21'h600 + 21'(i), 8'(i) ^ 8'hA5);
        put(21'h600, 8'hD0);
        wait_ready("R9 ready full");
        chk("R12 pgm err kept", status, 8'h90);
        chk("R8 full first", bmem[10'h600], 8'hA5);
        chk("R8 full last", bmem[10'h61F], 8'hBA);
        chk("R8 full drained", expq.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule